// File: doc/BRIEF.md
# Stepped soft-start current reference

This block generates the digital target code that a battery charger's current loop follows. Two programmed codes are kept ready: one for precharge and one for fast charge. A mode input chooses between them. The output code never jumps straight to the chosen target. It climbs from zero in a fixed number of equal increments, with one increment per step interval. The step interval is counted in pulses of an external time base. By default each pulse is 100 µs and each step is 16 pulses (1.6 ms), so the full ramp takes about 12.8 ms.

The ramp restarts from zero in three cases: on every fast-charge entry event, when charging is disabled, and when a battery-short flag is raised. After a short, the ceiling is limited to a cap code worth 1.25 A. The cap stays in force until the next fast-charge entry or until charging is disabled. After reset, the block holds its output at zero until the enable input has been high for a power-up qualification time, 500 pulses or 50 ms by default. A done flag reports that the ramp has reached the active target.

Top module: `chg_iref_ramp`

## Requirements
- R1: After reset `iref_code` and `ramp_done` are 0. The output stays 0 until `chg_en` has been high for `QUAL_TICKS` consecutive time-base pulses. Dropping `chg_en` before that point restarts the qualification count from zero.
- R2: Once qualified, the ramp index advances by one after every `STEP_TICKS` time-base pulses and stops at `STEPS`. At index k < `STEPS` the output is k·floor(T/`STEPS`). At index `STEPS` the output is exactly T, where T is the active target.
- R3: `mode_fast` = 0 selects `pre_code` as the target and `mode_fast` = 1 selects `fast_code`.
- R4: A `fast_entry` pulse resets the ramp index and the step timer, so `iref_code` is 0 in the cycle after the pulse and the ramp climbs again from there.
- R5: `bat_short` sampled high while qualified and enabled makes `iref_code` 0 in the next cycle and restarts the ramp. From then on the target is min(T, `CAP_CODE`) until a `fast_entry` pulse arrives without `bat_short`, or until `chg_en` falls.
- R6: `chg_en` low makes `iref_code` 0 in the next cycle and resets the step timer. When `chg_en` rises again, the ramp starts at once without a second qualification wait.
- R7: A target change during the ramp takes effect in the same cycle at the current index. The ramp does not restart, and the output never exceeds the active target.
- R8: `ramp_done` is 1 exactly when `chg_en` is high, the block is qualified and `iref_code` equals the active target.
- R9: When `bat_short` and `fast_entry` are both high in one qualified cycle, the short takes priority: the cap becomes active and the ramp restarts from zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| chg_en | input | 1 | Charge enable |
| mode_fast | input | 1 | 1: fast-charge target, 0: precharge target |
| fast_code | input | CODE_W | Programmed fast-charge current code |
| pre_code | input | CODE_W | Programmed precharge current code |
| fast_entry | input | 1 | One-cycle pulse on entry into fast charge |
| bat_short | input | 1 | Battery-short flag |
| tb_tick | input | 1 | Time-base pulse (one cycle per period) |
| iref_code | output | CODE_W | Current reference code for the loop |
| ramp_done | output | 1 | Output has reached the active target |

## Verification
The case to watch is a battery short that arrives in the same clock as a fast-charge entry. The entry alone would clear the cap, while the short sets it. The bench raises both flags in one cycle in the middle of a ramp, with a fast target above the cap. It then expects the output to fall to zero in the next cycle and to settle at the cap, not at the fast target. A behavioural model of the ramp, the cap and the qualification time is compared with the outputs on every clock, so a wrong priority shows up both in the cycle of the event and in the final level.

// File: rtl/chg_iref_pkg.sv
package chg_iref_pkg;

  // Output level at ramp index k: equal increments of floor(tgt/steps),
  // with the last index landing exactly on the target.
  function automatic int unsigned ramp_level(int unsigned tgt, int unsigned k,
                                             int unsigned steps);
    if (k >= steps) return tgt;
    return (tgt / steps) * k;
  endfunction

  // Ceiling applied after a battery short.
  function automatic int unsigned cap_code(int unsigned code, int unsigned cap,
                                           logic active);
    if (active && (code > cap)) return cap;
    return code;
  endfunction

endpackage

// File: rtl/chg_pwrup_hold.sv
module chg_pwrup_hold #(
  parameter int QUAL_TICKS = 500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic tick,
  output logic qual_ok
);
  localparam int QW = $clog2(QUAL_TICKS + 1);

  logic [QW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      qual_ok <= 1'b0;
    end else if (!qual_ok) begin
      if (!en) begin
        cnt_q <= '0;
      end else if (tick) begin
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == QW'(QUAL_TICKS - 1)) qual_ok <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/chg_step_seq.sv
module chg_step_seq #(
  parameter int STEPS      = 8,
  parameter int STEP_TICKS = 16
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           restart,
  input  logic                           tick,
  output logic [$clog2(STEPS+1)-1:0]     step_idx,
  output logic                           step_adv
);
  localparam int KW = $clog2(STEPS + 1);
  localparam int SW = (STEP_TICKS > 1) ? $clog2(STEP_TICKS) : 1;

  logic [SW-1:0] sc_q;
  logic          at_top;

  assign at_top   = (step_idx == KW'(STEPS));
  assign step_adv = tick && !at_top && (sc_q == SW'(STEP_TICKS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sc_q     <= '0;
      step_idx <= '0;
    end else if (restart) begin
      sc_q     <= '0;
      step_idx <= '0;
    end else if (tick && !at_top) begin
      if (step_adv) begin
        sc_q     <= '0;
        step_idx <= step_idx + 1'b1;
      end else begin
        sc_q <= sc_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/chg_tgt_sel.sv
module chg_tgt_sel
  import chg_iref_pkg::*;
#(
  parameter int CODE_W   = 12,
  parameter int CAP_CODE = 1250
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              qual_ok,
  input  logic              mode_fast,
  input  logic [CODE_W-1:0] fast_code,
  input  logic [CODE_W-1:0] pre_code,
  input  logic              fast_entry,
  input  logic              bat_short,
  output logic              short_lat,
  output logic [CODE_W-1:0] tgt
);
  logic [CODE_W-1:0] raw_tgt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    short_lat <= 1'b0;
    else if (!en)                  short_lat <= 1'b0;
    else if (bat_short && qual_ok) short_lat <= 1'b1;
    else if (fast_entry)           short_lat <= 1'b0;
  end

  assign raw_tgt = mode_fast ? fast_code : pre_code;
  assign tgt     = CODE_W'(cap_code(32'(raw_tgt), CAP_CODE, short_lat));

endmodule

// File: rtl/chg_iref_ramp.sv
module chg_iref_ramp
  import chg_iref_pkg::*;
#(
  parameter int CODE_W     = 12,
  parameter int STEPS      = 8,
  parameter int STEP_TICKS = 16,
  parameter int QUAL_TICKS = 500,
  parameter int CAP_CODE   = 1250
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chg_en,
  input  logic              mode_fast,
  input  logic [CODE_W-1:0] fast_code,
  input  logic [CODE_W-1:0] pre_code,
  input  logic              fast_entry,
  input  logic              bat_short,
  input  logic              tb_tick,
  output logic [CODE_W-1:0] iref_code,
  output logic              ramp_done
);
  localparam int KW = $clog2(STEPS + 1);

  logic              pwr_ok;
  logic              run;
  logic              restart;
  logic              step_adv;
  logic [KW-1:0]     step_idx;
  logic              short_lat;
  logic [CODE_W-1:0] tgt_active;

  chg_pwrup_hold #(.QUAL_TICKS(QUAL_TICKS)) u_hold (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (chg_en),
    .tick    (tb_tick),
    .qual_ok (pwr_ok)
  );

  assign run     = chg_en && pwr_ok;
  assign restart = !run || bat_short || fast_entry;

  chg_step_seq #(.STEPS(STEPS), .STEP_TICKS(STEP_TICKS)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .restart  (restart),
    .tick     (tb_tick),
    .step_idx (step_idx),
    .step_adv (step_adv)
  );

  chg_tgt_sel #(.CODE_W(CODE_W), .CAP_CODE(CAP_CODE)) u_tgt (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (chg_en),
    .qual_ok    (pwr_ok),
    .mode_fast  (mode_fast),
    .fast_code  (fast_code),
    .pre_code   (pre_code),
    .fast_entry (fast_entry),
    .bat_short  (bat_short),
    .short_lat  (short_lat),
    .tgt        (tgt_active)
  );

  assign iref_code = CODE_W'(ramp_level(32'(tgt_active), 32'(step_idx), STEPS));
  assign ramp_done = run && (iref_code == tgt_active);

endmodule

// File: rtl/chg_iref_ramp_chk.sv
module chg_iref_ramp_chk #(
  parameter int CODE_W   = 12,
  parameter int STEPS    = 8,
  parameter int KW       = 4,
  parameter int CAP_CODE = 1250
) (
  input logic              clk,
  input logic              rst_n,
  input logic              chg_en,
  input logic              mode_fast,
  input logic              fast_entry,
  input logic              bat_short,
  input logic [CODE_W-1:0] fast_code,
  input logic              pwr_ok,
  input logic [KW-1:0]     step_idx,
  input logic              step_adv,
  input logic              short_lat,
  input logic [CODE_W-1:0] tgt_active,
  input logic [CODE_W-1:0] iref_code,
  input logic              ramp_done
);

  AST_HOLD_BEFORE_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_ok |-> (iref_code == '0)); // R1

  AST_STEP_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (step_idx != $past(step_idx)) |-> ((step_idx == '0) || (step_idx == $past(step_idx) + 1'b1))); // R2

  AST_STEP_ON_ADV: assert property (@(posedge clk) disable iff (!rst_n)
    (step_adv && chg_en && pwr_ok && !bat_short && !fast_entry) |=> (step_idx == $past(step_idx) + 1'b1)); // R2

  AST_FAST_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_fast && !short_lat && (step_idx == KW'(STEPS))) |-> (iref_code == fast_code)); // R3

  AST_ENTRY_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    fast_entry |=> (step_idx == '0)); // R4

  AST_SHORT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    bat_short |=> (iref_code == '0)); // R5

  AST_SHORT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    short_lat |-> (iref_code <= CODE_W'(CAP_CODE))); // R5

  AST_DISABLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !chg_en |=> (iref_code == '0)); // R6

  AST_NO_OVERSHOOT: assert property (@(posedge clk) disable iff (!rst_n)
    iref_code <= tgt_active); // R7

  AST_DONE_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
    ramp_done |-> (chg_en && pwr_ok)); // R8

  AST_SHORT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (bat_short && fast_entry && chg_en && pwr_ok) |=> short_lat); // R9

endmodule

bind chg_iref_ramp chg_iref_ramp_chk #(
  .CODE_W(CODE_W), .STEPS(STEPS), .KW(KW), .CAP_CODE(CAP_CODE)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .chg_en     (chg_en),
  .mode_fast  (mode_fast),
  .fast_entry (fast_entry),
  .bat_short  (bat_short),
  .fast_code  (fast_code),
  .pwr_ok     (pwr_ok),
  .step_idx   (step_idx),
  .step_adv   (step_adv),
  .short_lat  (short_lat),
  .tgt_active (tgt_active),
  .iref_code  (iref_code),
  .ramp_done  (ramp_done)
);

// File: tb/test_chg_iref_ramp.sv
module test_chg_iref_ramp;
  localparam int CW    = 12;
  localparam int NST   = 8;
  localparam int STK   = 16;
  localparam int QTK   = 500;
  localparam int CAP   = 1250;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          chg_en = 1'b0;
  logic          mode_fast = 1'b0;
  logic [CW-1:0] fast_code = '0;
  logic [CW-1:0] pre_code = '0;
  logic          fast_entry = 1'b0;
  logic          bat_short = 1'b0;
  logic          tb_tick = 1'b0;
  logic [CW-1:0] iref_code;
  logic          ramp_done;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  string phase = "R1";
  bit finished = 1'b0;

  // reference model state
  int  m_pcnt = 0;
  bit  m_pok = 0;
  int  m_k = 0;
  int  m_sc = 0;
  bit  m_short = 0;

  chg_iref_ramp #(.CODE_W(CW), .STEPS(NST), .STEP_TICKS(STK),
                  .QUAL_TICKS(QTK), .CAP_CODE(CAP)) i_chg_iref_ramp (
    .clk(clk), .rst_n(rst_n), .chg_en(chg_en), .mode_fast(mode_fast),
    .fast_code(fast_code), .pre_code(pre_code), .fast_entry(fast_entry),
    .bat_short(bat_short), .tb_tick(tb_tick), .iref_code(iref_code),
    .ramp_done(ramp_done)
  );

  always #5 clk = ~clk;

  function automatic int exp_target();
    int t;
    t = mode_fast ? int'(fast_code) : int'(pre_code);
    if (m_short && t > CAP) t = CAP;
    return t;
  endfunction

  function automatic int exp_level();
    int t;
    t = exp_target();
    if (m_k >= NST) return t;
    return m_k * (t / NST);
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // time base: two pulses out of every three cycles
  always @(posedge clk) begin
    cyc <= cyc + 1;
    #2 tb_tick = ((cyc % 3) != 0);
  end

  // reference model update
  always @(posedge clk) begin
    if (!rst_n) begin
      m_pcnt = 0; m_pok = 0; m_k = 0; m_sc = 0; m_short = 0;
    end else begin
      bit run_o, pok_n, short_n;
      int pcnt_n, k_n, sc_n;
      run_o = chg_en && m_pok;
      pok_n = m_pok; pcnt_n = m_pcnt;
      if (!m_pok) begin
        if (!chg_en) pcnt_n = 0;
        else if (tb_tick) begin
          pcnt_n = m_pcnt + 1;
          if (pcnt_n == QTK) pok_n = 1;
        end
      end
      short_n = m_short;
      if (!chg_en) short_n = 0;
      else if (bat_short && m_pok) short_n = 1;
      else if (fast_entry) short_n = 0;
      k_n = m_k; sc_n = m_sc;
      if (!run_o || bat_short || fast_entry) begin
        k_n = 0; sc_n = 0;
      end else if (tb_tick && m_k < NST) begin
        if (m_sc == STK - 1) begin sc_n = 0; k_n = m_k + 1; end
        else sc_n = m_sc + 1;
      end
      m_pok = pok_n; m_pcnt = pcnt_n; m_short = short_n; m_k = k_n; m_sc = sc_n;
    end
  end

  // cycle-by-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk({phase, " level"}, int'(iref_code), exp_level());
      chk({phase, " done / R8"}, int'(ramp_done),
          int'(chg_en && m_pok && (exp_level() == exp_target())));
    end
  end

  task automatic cycles(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic pulse_entry();
    fast_entry = 1'b1; cycles(1); fast_entry = 1'b0;
  endtask

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    #1;
    chk("R1 reset iref", int'(iref_code), 0);
    chk("R1 reset done", int'(ramp_done), 0);
    cycles(4);
    rst_n = 1'b1;
    fast_code = 12'd2000; pre_code = 12'd300; mode_fast = 1'b1;

    // R1: qualification restarts when enable drops early
    phase = "R1";
    chg_en = 1'b1; cycles(600);
    @(negedge clk); chk("R1 partial qual iref", int'(iref_code), 0);
    cycles(1);
    chg_en = 1'b0; cycles(5);
    chg_en = 1'b1; cycles(700);
    @(negedge clk); chk("R1 requalify still zero", int'(iref_code), 0);
    cycles(100);

    // R2 / R8: full ramp to fast target
    phase = "R2";
    cycles(260);
    @(negedge clk);
    chk("R2 ramp top", int'(iref_code), 2000);
    chk("R8 done at top", int'(ramp_done), 1);

    // R3: precharge target selected
    phase = "R3";
    cycles(1);
    mode_fast = 1'b0; cycles(2);
    @(negedge clk); chk("R3 precharge target", int'(iref_code), 300);
    cycles(1);

    // R4: fast entry restarts
    phase = "R4";
    mode_fast = 1'b1; pulse_entry();
    @(negedge clk); chk("R4 restart zero", int'(iref_code), 0);
    cycles(100);

    // R7: target change mid-ramp, non-multiple of STEPS
    phase = "R7";
    fast_code = 12'd3001; cycles(200);
    @(negedge clk); chk("R7 new target top", int'(iref_code), 3001);
    cycles(1);

    // R5: battery short mid-ramp
    phase = "R5";
    pulse_entry(); cycles(60);
    bat_short = 1'b1; cycles(1); bat_short = 1'b0;
    @(negedge clk); chk("R5 short zero", int'(iref_code), 0);
    cycles(260);
    @(negedge clk); chk("R5 capped top", int'(iref_code), CAP);
    cycles(1);
    pulse_entry(); cycles(260);
    @(negedge clk); chk("R5 cap cleared by entry", int'(iref_code), 3001);
    cycles(1);

    // R9: short and entry in the same cycle
    phase = "R9";
    pulse_entry(); cycles(70);
    bat_short = 1'b1; fast_entry = 1'b1; cycles(1);
    bat_short = 1'b0; fast_entry = 1'b0;
    @(negedge clk); chk("R9 zero after both", int'(iref_code), 0);
    cycles(260);
    @(negedge clk); chk("R9 short wins cap", int'(iref_code), CAP);
    cycles(1);

    // R6: disable zeroes, re-enable ramps without qualification wait
    phase = "R6";
    chg_en = 1'b0; cycles(1);
    @(negedge clk); chk("R6 disable zero", int'(iref_code), 0);
    cycles(10);
    chg_en = 1'b1; cycles(40);
    @(negedge clk); chk("R6 no second wait", int'(iref_code), 3001 / NST);
    cycles(300);
    @(negedge clk); chk("R6 ramp after reenable", int'(iref_code), 3001);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule